// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the bus-facing command decoder of a parallel NOR flash that uses the common command set with a status register. Its storage array is small and internal. Each write cycle on the bus carries a command code in its low data byte, or an operand that follows a code. A multi-step state machine walks the command sequences: single program, sector erase with confirm, status clear, lock/unlock with confirm, status read, identifier read, query mode and buffered write. Program and erase finish in the cycle that accepts them; the block models no flash timing. A read-only input turns every program or erase into an error report in the status byte.

Reads are combinational. The last latched command selects what a read returns: array bytes, the status byte, identifier words or query bytes. The read is sized by the access width (byte, halfword or word). Array accesses of 16 and 32 bits follow a byte-order input.

States: `S_READY` (first cycle of a command), `S_PROG` (waiting for the program datum), `S_ERASE_CF` (waiting for the erase confirm), `S_LOCK_CF` (waiting for the lock confirm), `S_QUERY` (query mode held), `S_BUF_CNT` (waiting for the word count), `S_BUF_DATA` (taking buffered data words) and `S_BUF_CF` (waiting for the buffered-write confirm). Transitions:

- `S_READY` goes to `S_PROG` on 0x10 or 0x40, to `S_ERASE_CF` on 0x20, to `S_LOCK_CF` on 0x60, to `S_QUERY` on 0x98 and to `S_BUF_CNT` on 0xE8.
- `S_READY` stays in `S_READY` on 0x70, 0x90, 0x50, 0xFF, 0xF0, 0x00 and on unknown codes.
- `S_PROG` returns to `S_READY` on any write.
- `S_ERASE_CF`, `S_LOCK_CF` and `S_BUF_CF` return to `S_READY` on any write. A wrong code also clears the latched command.
- `S_QUERY` stays until 0xFF.
- `S_BUF_CNT` goes to `S_BUF_DATA`.
- `S_BUF_DATA` loops until the count is spent, then goes to `S_BUF_CF`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the array reads as all-ones, the read mode is array, and the status byte is 0x00.
- R2: In `S_READY`, a write of 0x10 or 0x40 arms a program. The next write stores its data at its address and its size, sets status bit 7, and returns to `S_READY`. Later reads return status.
- R3: In `S_READY`, a write of 0x20 erases the whole sector that holds the address to 0xFF at once and sets status bit 7. The next write must be 0xD0, which keeps reads on status. 0xFF, or any other value, clears the latched command to array reads. Other sectors are unchanged.
- R4: In `S_READY`, 0x50 zeroes the status byte and selects array reads. 0xFF, 0xF0 and 0x00 also select array reads.
- R5: With a program, erase, lock, status (0x70) or buffered-write command latched, a read returns the status byte in the low byte of each 16-bit device lane. A word read gives {8'h00, S, 8'h00, S}.
- R6: After 0x90, a read uses index = address bits [7:2]. Index 0 gives the manufacturer code, index 1 gives the device code, and any other index gives 0. The 16-bit value is repeated in each device lane.
- R7: After 0x98, the block stays in query mode on any write except 0xFF. A read at index = address bits [7:2] gives, in each lane, 0x51, 0x52, 0x59 and 0x01 at indexes 0x10 to 0x13, log2 of the array size at index 0x27, and 0 elsewhere.
- R8: 0xE8 starts a buffered write and sets status bit 7. The next write gives a word count N from data bits [15:0]. The next N+1 writes each store one datum. A following 0xD0 completes the write, and any other value clears the command to array reads.
- R9: 0x60 followed by 0xD0 or 0x01 sets status bit 7 and keeps status reads. Any other second value selects array reads.
- R10: With read-only high, program and buffered-write data set status bit 4, erase sets status bit 5, and the array is not changed.
- R11: For halfword and word accesses, byte order in the array is little-endian when big_endian is 0 and big-endian when it is 1, for both reads and writes.
- R12: An unknown first-cycle code leaves the machine in `S_READY` with array reads selected.
- R13: A byte read returns zero on bits [31:8], and a halfword read returns zero on bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address into the array |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| bus_wr | input | 1 | Write cycle strobe, one per clock |
| bus_wdata | input | 32 | Write data; command code in bits [7:0] |
| big_endian | input | 1 | Byte order for multi-byte array accesses |
| read_only | input | 1 | Turns program and erase into status errors |
| bus_rdata | output | 32 | Read data for the current address and size |

## Verification
A wrong state or a wrong latched command shows up at the next read as the wrong data source. For example, status appears where array bytes are expected, or query bytes appear in place of identifiers, so the error is visible in the same cycle as the read. A wrong count or a wrong sector mask shows up only at the first read of the affected bytes once the block is back in array mode. For that reason the bench compares every cycle's read port against its model and rereads every touched region.

// File: rtl/pfseq_pkg.sv
package pfseq_pkg;
    typedef enum logic [2:0] {
        S_READY, S_PROG, S_ERASE_CF, S_LOCK_CF,
        S_QUERY, S_BUF_CNT, S_BUF_DATA, S_BUF_CF
    } seq_state_e;

    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_ID, RM_QUERY} rd_mode_e;

    localparam logic [7:0] OP_NONE    = 8'h00;
    localparam logic [7:0] OP_PROG_A  = 8'h10;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_ERASE_B = 8'h28;
    localparam logic [7:0] OP_PROG_B  = 8'h40;
    localparam logic [7:0] OP_CLR     = 8'h50;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_STAT    = 8'h70;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_BUFWR   = 8'hE8;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_LOCKALT = 8'h01;
    localparam logic [7:0] OP_ARRAY   = 8'hFF;
endpackage

// File: rtl/pfseq_array.sv
module pfseq_array #(
    parameter int SECT_BYTES = 64,
    parameter int NUM_SECT   = 4,
    parameter int AW         = $clog2(SECT_BYTES * NUM_SECT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          erase,
    input  logic          big_endian,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    localparam int MEM_BYTES = SECT_BYTES * NUM_SECT;
    localparam int SW        = $clog2(SECT_BYTES);

    logic [7:0] mem [MEM_BYTES];
    int         nbytes;

    always_comb nbytes = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;

    // lane position of byte k within an access of n bytes
    function automatic int lane_pos(input int k, input int n, input logic be);
        return be ? (n - 1 - k) : k;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < MEM_BYTES; m++) mem[m] <= 8'hFF;
        end else if (erase) begin
            for (int m = 0; m < MEM_BYTES; m++)
                if ((AW'(m) >> SW) == (addr >> SW)) mem[m] <= 8'hFF;
        end else if (we) begin
            for (int k = 0; k < 4; k++)
                if (k < nbytes)
                    mem[addr + AW'(k)] <= wdata[8*lane_pos(k, nbytes, big_endian) +: 8];
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < 4; k++)
            if (k < nbytes)
                rdata[8*lane_pos(k, nbytes, big_endian) +: 8] = mem[addr + AW'(k)];
    end
endmodule

// File: rtl/pfseq_ctrl.sv
module pfseq_ctrl
    import pfseq_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    code,
    input  logic [CW-1:0] count_in,
    input  logic          read_only,
    output logic          mem_we,
    output logic          erase_en,
    output rd_mode_e      rd_mode,
    output logic [7:0]    status
);
    seq_state_e    state, state_n;
    logic [7:0]    cmd, cmd_n, status_n;
    logic [CW-1:0] count, count_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_READY;
            cmd    <= OP_NONE;
            status <= 8'h00;
            count  <= '0;
        end else begin
            state  <= state_n;
            cmd    <= cmd_n;
            status <= status_n;
            count  <= count_n;
        end
    end

    always_comb begin
        state_n  = state;
        cmd_n    = cmd;
        status_n = status;
        count_n  = count;
        mem_we   = 1'b0;
        erase_en = 1'b0;
        if (wr_en) begin
            unique case (state)
                S_READY: begin
                    unique case (code)
                        OP_PROG_A, OP_PROG_B: begin state_n = S_PROG; cmd_n = code; end
                        OP_ERASE: begin
                            state_n = S_ERASE_CF;
                            cmd_n   = code;
                            if (read_only) status_n = status_n | 8'h20;
                            else           erase_en = 1'b1;
                            status_n = status_n | 8'h80;
                        end
                        OP_CLR:   begin status_n = 8'h00; cmd_n = OP_NONE; end
                        OP_LOCK:  begin state_n = S_LOCK_CF; cmd_n = code; end
                        OP_STAT, OP_IDENT: cmd_n = code;
                        OP_QUERY: begin state_n = S_QUERY; cmd_n = code; end
                        OP_BUFWR: begin
                            state_n  = S_BUF_CNT;
                            cmd_n    = code;
                            status_n = status | 8'h80;
                        end
                        default:  cmd_n = OP_NONE;
                    endcase
                end
                S_PROG: begin
                    if (read_only) status_n = status_n | 8'h10;
                    else           mem_we   = 1'b1;
                    status_n = status_n | 8'h80;
                    state_n  = S_READY;
                end
                S_ERASE_CF: begin
                    state_n = S_READY;
                    if (code == OP_CONFIRM) status_n = status | 8'h80;
                    else                    cmd_n    = OP_NONE;
                end
                S_LOCK_CF: begin
                    state_n = S_READY;
                    if (code == OP_CONFIRM || code == OP_LOCKALT) status_n = status | 8'h80;
                    else                                           cmd_n    = OP_NONE;
                end
                S_QUERY: begin
                    if (code == OP_ARRAY) begin state_n = S_READY; cmd_n = OP_NONE; end
                end
                S_BUF_CNT: begin
                    count_n = count_in;
                    state_n = S_BUF_DATA;
                end
                S_BUF_DATA: begin
                    if (read_only) status_n = status_n | 8'h10;
                    else           mem_we   = 1'b1;
                    status_n = status_n | 8'h80;
                    if (count == '0) state_n = S_BUF_CF;
                    count_n = count - 1'b1;
                end
                S_BUF_CF: begin
                    state_n = S_READY;
                    if (code == OP_CONFIRM) status_n = status | 8'h80;
                    else                    cmd_n    = OP_NONE;
                end
                default: begin state_n = S_READY; cmd_n = OP_NONE; end
            endcase
        end
    end

    always_comb begin
        unique case (cmd)
            OP_PROG_A, OP_PROG_B, OP_ERASE, OP_ERASE_B, OP_CLR,
            OP_LOCK, OP_STAT, OP_BUFWR: rd_mode = RM_STATUS;
            OP_IDENT: rd_mode = RM_ID;
            OP_QUERY: rd_mode = RM_QUERY;
            default:  rd_mode = RM_ARRAY;
        endcase
    end

    a_r2_prog_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PROG && wr_en) |=> (state == S_READY && status[7]));
    a_r3_erase_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY && wr_en && code == OP_ERASE) |=> (state == S_ERASE_CF && status[7]));
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY && wr_en && code == OP_CLR) |=> (status == 8'h00 && rd_mode == RM_ARRAY));
    a_r7_query_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_QUERY && wr_en && code != OP_ARRAY) |=> (state == S_QUERY && rd_mode == RM_QUERY));
    a_r8_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUF_CF && wr_en && code != OP_CONFIRM) |=> (state == S_READY && rd_mode == RM_ARRAY));
    a_r10_prog_error: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PROG && wr_en && read_only) |=> status[4]);
endmodule

// File: rtl/pfseq_rdmux.sv
module pfseq_rdmux
    import pfseq_pkg::*;
#(
    parameter int          DEV_BYTES  = 2,
    parameter int          BANK_BYTES = 4,
    parameter int          AW         = 8,
    parameter logic [15:0] MFR_ID     = 16'h0089,
    parameter logic [15:0] DEV_ID     = 16'h1234
) (
    input  rd_mode_e      mode,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic [7:0]    status,
    input  logic [31:0]   arr_data,
    output logic [31:0]   rd_data
);
    localparam int LW    = DEV_BYTES * 8;
    localparam int LANES = 4 / DEV_BYTES;
    localparam int BSH   = $clog2(BANK_BYTES);

    int          idx;
    logic [LW-1:0] id_val;
    logic [7:0]  qry_val;
    logic [31:0] stat_w, id_w, qry_w, raw;

    always_comb begin
        idx = int'(addr >> BSH);
        unique case (idx)
            0:       id_val = LW'(MFR_ID);
            1:       id_val = LW'(DEV_ID);
            default: id_val = '0;
        endcase
        unique case (idx)
            16:      qry_val = 8'h51;
            17:      qry_val = 8'h52;
            18:      qry_val = 8'h59;
            19:      qry_val = 8'h01;
            39:      qry_val = 8'(AW);
            default: qry_val = 8'h00;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign stat_w[l*LW +: LW] = LW'(status);
        assign id_w[l*LW +: LW]   = id_val;
        assign qry_w[l*LW +: LW]  = LW'(qry_val);
    end

    always_comb begin
        unique case (mode)
            RM_STATUS: raw = stat_w;
            RM_ID:     raw = id_w;
            RM_QUERY:  raw = qry_w;
            default:   raw = arr_data;
        endcase
        unique case (size)
            2'd0:    rd_data = {24'h0, raw[7:0]};
            2'd1:    rd_data = {16'h0, raw[15:0]};
            default: rd_data = raw;
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import pfseq_pkg::*;
#(
    parameter int          SECT_BYTES = 64,
    parameter int          NUM_SECT   = 4,
    parameter int          DEV_BYTES  = 2,
    parameter logic [15:0] MFR_ID     = 16'h0089,
    parameter logic [15:0] DEV_ID     = 16'h1234,
    parameter int          ADDR_W     = $clog2(SECT_BYTES * NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              big_endian,
    input  logic              read_only,
    output logic [31:0]       bus_rdata
);
    localparam int CW = DEV_BYTES * 8;

    logic        mem_we, erase_en;
    rd_mode_e    rd_mode;
    logic [7:0]  status;
    logic [31:0] arr_data;

    pfseq_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .code(bus_wdata[7:0]),
        .count_in(bus_wdata[CW-1:0]), .read_only(read_only),
        .mem_we(mem_we), .erase_en(erase_en), .rd_mode(rd_mode), .status(status)
    );

    pfseq_array #(.SECT_BYTES(SECT_BYTES), .NUM_SECT(NUM_SECT), .AW(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .erase(erase_en),
        .big_endian(big_endian), .addr(bus_addr), .size(bus_size),
        .wdata(bus_wdata), .rdata(arr_data)
    );

    pfseq_rdmux #(.DEV_BYTES(DEV_BYTES), .BANK_BYTES(4), .AW(ADDR_W),
                  .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rdmux (
        .mode(rd_mode), .addr(bus_addr), .size(bus_size), .status(status),
        .arr_data(arr_data), .rd_data(bus_rdata)
    );
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        big_endian = 1'b0;
    logic        read_only = 1'b0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    logic [7:0] mm [256];
    int   mst;      // 0 ready,1 prog,2 erase cf,3 lock cf,4 query,5 count,6 data,7 confirm
    logic [7:0] mcmd, mstat;
    int   mcnt;

    flash_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .big_endian(big_endian),
        .read_only(read_only), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int nb(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic void mstore(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
        int n = nb(sz);
        for (int k = 0; k < n; k++)
            mm[8'(a + k)] = big_endian ? d[8*(n-1-k) +: 8] : d[8*k +: 8];
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
        logic [7:0] c = d[7:0];
        case (mst)
            0: begin
                if (c == 8'h10 || c == 8'h40) begin mst = 1; mcmd = c; end
                else if (c == 8'h20) begin
                    mst = 2; mcmd = c;
                    if (read_only) mstat |= 8'h20;
                    else for (int m = 0; m < 256; m++) if (m / 64 == a / 64) mm[m] = 8'hFF;
                    mstat |= 8'h80;
                end
                else if (c == 8'h50) begin mstat = 0; mcmd = 0; end
                else if (c == 8'h60) begin mst = 3; mcmd = c; end
                else if (c == 8'h70 || c == 8'h90) mcmd = c;
                else if (c == 8'h98) begin mst = 4; mcmd = c; end
                else if (c == 8'hE8) begin mst = 5; mcmd = c; mstat |= 8'h80; end
                else mcmd = 0;
            end
            1: begin
                if (read_only) mstat |= 8'h10; else mstore(a, d, sz);
                mstat |= 8'h80; mst = 0;
            end
            2: begin mst = 0; if (c == 8'hD0) mstat |= 8'h80; else mcmd = 0; end
            3: begin mst = 0; if (c == 8'hD0 || c == 8'h01) mstat |= 8'h80; else mcmd = 0; end
            4: if (c == 8'hFF) begin mst = 0; mcmd = 0; end
            5: begin mcnt = int'(d[15:0]); mst = 6; end
            6: begin
                if (read_only) mstat |= 8'h10; else mstore(a, d, sz);
                mstat |= 8'h80;
                if (mcnt == 0) mst = 7;
                mcnt--;
            end
            default: begin mst = 0; if (c == 8'hD0) mstat |= 8'h80; else mcmd = 0; end
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a, input logic [1:0] sz);
        logic [31:0] w = 0;
        int n = nb(sz);
        int ix = a / 4;
        logic [15:0] v;
        case (mcmd)
            8'h10, 8'h20, 8'h28, 8'h40, 8'h50, 8'h60, 8'h70, 8'hE8: w = {8'h00, mstat, 8'h00, mstat};
            8'h90: begin
                v = (ix == 0) ? 16'h0089 : (ix == 1) ? 16'h1234 : 16'h0000;
                w = {v, v};
            end
            8'h98: begin
                case (ix)
                    16: v = 16'h51; 17: v = 16'h52; 18: v = 16'h59; 19: v = 16'h01;
                    39: v = 16'h08; default: v = 16'h00;
                endcase
                w = {v, v};
            end
            default:
                for (int k = 0; k < n; k++)
                    w[8*(big_endian ? n-1-k : k) +: 8] = mm[8'(a + k)];
        endcase
        if (n == 1) w[31:8] = 0;
        else if (n == 2) w[31:16] = 0;
        return w;
    endfunction

    function automatic string mode_tag();
        case (mcmd)
            8'h90: return "R6";
            8'h98: return "R7";
            8'h00, 8'hFF: return "R11";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) check(mode_tag(), bus_rdata, model_read(bus_addr, bus_size));
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd0);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        model_write(a, d, sz);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp);
        @(posedge clk); #1;
        bus_addr = a; bus_size = sz;
        @(negedge clk);
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 256; m++) mm[m] = 8'hFF;
        mst = 0; mcmd = 0; mstat = 0; mcnt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd("R1", 8'h00, 2'd2, 32'hFFFF_FFFF);
        wr(8'h00, 32'h70);
        rd("R1", 8'h00, 2'd2, 32'h0000_0000);

        // R2: program, status replicated (R5), masking (R13)
        wr(8'h10, 32'h40);
        wr(8'h10, 32'hA5);
        rd("R5", 8'h00, 2'd2, 32'h0080_0080);
        rd("R13", 8'h00, 2'd0, 32'h0000_0080);
        wr(8'h00, 32'hFF);
        rd("R2", 8'h10, 2'd0, 32'h0000_00A5);
        wr(8'h40, 32'h10);
        wr(8'h40, 32'h5A);
        wr(8'h00, 32'hFF);

        // R11: byte order
        wr(8'h20, 32'h10);
        wr(8'h20, 32'h1122_3344, 2'd2);
        wr(8'h00, 32'hFF);
        rd("R11", 8'h20, 2'd0, 32'h0000_0044);
        rd("R11", 8'h20, 2'd1, 32'h0000_3344);
        big_endian = 1'b1;
        rd("R11", 8'h20, 2'd1, 32'h0000_4433);
        rd("R11", 8'h20, 2'd2, 32'h4433_2211);
        wr(8'h30, 32'h10);
        wr(8'h30, 32'hBEEF, 2'd1);
        big_endian = 1'b0;
        wr(8'h00, 32'hFF);
        rd("R11", 8'h30, 2'd1, 32'h0000_EFBE);

        // R3: erase sector 0, other sector untouched
        wr(8'h23, 32'h20);
        wr(8'h23, 32'hD0);
        rd("R3", 8'h20, 2'd2, 32'h0080_0080);
        wr(8'h00, 32'hFF);
        rd("R3", 8'h20, 2'd2, 32'hFFFF_FFFF);
        rd("R3", 8'h10, 2'd0, 32'h0000_00FF);
        rd("R3", 8'h40, 2'd0, 32'h0000_005A);
        wr(8'h80, 32'h20);
        wr(8'h80, 32'h33);
        rd("R3", 8'h40, 2'd2, 32'hFFFF_FF5A);

        // R4: clear and return codes
        wr(8'h00, 32'h50);
        wr(8'h00, 32'h70);
        rd("R4", 8'h00, 2'd2, 32'h0000_0000);
        wr(8'h00, 32'hF0);
        rd("R4", 8'h40, 2'd0, 32'h0000_005A);

        // R6: identifier read
        wr(8'h00, 32'h90);
        rd("R6", 8'h00, 2'd2, 32'h0089_0089);
        rd("R6", 8'h04, 2'd2, 32'h1234_1234);
        rd("R6", 8'h08, 2'd2, 32'h0000_0000);
        rd("R6", 8'h04, 2'd1, 32'h0000_1234);
        wr(8'h00, 32'h00);
        rd("R4", 8'h40, 2'd0, 32'h0000_005A);

        // R7: query mode
        wr(8'h00, 32'h98);
        rd("R7", 8'h40, 2'd2, 32'h0051_0051);
        rd("R7", 8'h44, 2'd2, 32'h0052_0052);
        rd("R7", 8'h48, 2'd2, 32'h0059_0059);
        rd("R7", 8'h9C, 2'd2, 32'h0008_0008);
        rd("R7", 8'h00, 2'd2, 32'h0000_0000);
        wr(8'h00, 32'h12);
        rd("R7", 8'h40, 2'd2, 32'h0051_0051);
        wr(8'h00, 32'hFF);
        rd("R7", 8'h40, 2'd0, 32'h0000_005A);

        // R8: buffered write, count masked to 16 bits
        wr(8'h80, 32'hE8);
        wr(8'h80, 32'h0001_0001, 2'd2);
        wr(8'h80, 32'hCAFE_F00D, 2'd2);
        wr(8'h84, 32'h0102_0304, 2'd2);
        rd("R8", 8'h00, 2'd2, 32'h0080_0080);
        wr(8'h00, 32'hD0);
        rd("R8", 8'h00, 2'd2, 32'h0080_0080);
        wr(8'h00, 32'hFF);
        rd("R8", 8'h80, 2'd2, 32'hCAFE_F00D);
        rd("R8", 8'h84, 2'd2, 32'h0102_0304);
        wr(8'h88, 32'hE8);
        wr(8'h88, 32'h0);
        wr(8'h88, 32'h1111_1111, 2'd2);
        wr(8'h88, 32'h33);
        rd("R8", 8'h88, 2'd2, 32'h1111_1111);

        // R13: size masking in array mode
        rd("R13", 8'h80, 2'd1, 32'h0000_F00D);
        rd("R13", 8'h80, 2'd0, 32'h0000_000D);

        // R9: lock/unlock
        wr(8'h00, 32'h50);
        wr(8'h00, 32'h60);
        wr(8'h00, 32'h01);
        rd("R9", 8'h00, 2'd2, 32'h0080_0080);
        wr(8'h00, 32'h60);
        wr(8'h00, 32'h77);
        rd("R9", 8'h40, 2'd0, 32'h0000_005A);

        // R10: read-only errors, array unchanged
        read_only = 1'b1;
        wr(8'h00, 32'h50);
        wr(8'h40, 32'h40);
        wr(8'h40, 32'h00);
        rd("R10", 8'h40, 2'd0, 32'h0000_0090);
        wr(8'h40, 32'h20);
        rd("R10", 8'h40, 2'd0, 32'h0000_00B0);
        wr(8'h40, 32'hD0);
        wr(8'h00, 32'hFF);
        rd("R10", 8'h40, 2'd0, 32'h0000_005A);
        read_only = 1'b0;

        // R12: unknown code falls back to array reads
        wr(8'h00, 32'h90);
        wr(8'h00, 32'h3C);
        rd("R12", 8'h40, 2'd0, 32'h0000_005A);
        rd("R12", 8'h84, 2'd2, 32'h0102_0304);

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule